// File: doc/BRIEF.md
# Cumulative-Boundary Display Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a parallel RGB panel. It also reports the current pixel column and line, so that the layer logic downstream can follow the scan. It runs in the pixel clock domain. Software describes a frame as four running boundaries on each axis: where sync ends, where the back porch ends, where the active region ends, and where the line or frame ends. Each boundary is written as one less than the count of clocks or lines from the start of the line or frame. For example, a sync of S clocks followed by a back porch of B clocks gives a back-porch boundary of S-1+B.

Timing words are written into shadow copies first. A reload request then moves them into the working copy. It can do so at once, or at the end of the last line of the frame, so that a mode change never tears a frame. Polarity controls and the enable take effect on the edge that captures the write.

Top module: `disp_timing_gen`

## Requirements
- R1: A write to a timing word changes only its shadow copy. Scanning continues with the working values until a reload copies the shadow across.
- R2: The word addresses are 0 for the sync boundary, 1 for the back-porch boundary, 2 for the active boundary, 3 for the total, 4 for control and 5 for reload. In a timing word the horizontal value is in bits 27:16 and the vertical value is in bits 10:0.
- R3: `px_x` counts from 0 up to the horizontal total and then returns to 0. `px_y` advances by one on each horizontal return. After the vertical total it returns to 0.
- R4: Horizontal sync is active while `px_x` is at or below the horizontal sync boundary. Vertical sync is active while `px_y` is at or below the vertical sync boundary.
- R5: Data enable is active only when each counter is strictly above its back-porch boundary and at or below its active boundary.
- R6: Control bit 1 makes horizontal sync active-high, bit 2 does the same for vertical sync and bit 3 for data enable. When a bit is clear, that output is active-low. Control bit 4 drives `pclk_falling`, which selects the inverted pixel-clock edge.
- R7: Reload bit 0 copies all shadow values on the edge after the one that captures the request. The request then clears itself, so a later shadow write stays in the shadow copy.
- R8: Reload bit 1 copies the shadow values on the edge where both counters return from their totals. The request then clears itself. A request captured on that same edge waits for the following frame end.
- R9: Control bit 0 enables the block. While it is clear, both counters are held at 0 and every strobe sits at its inactive level. Once enabled, the scan starts from column 0, line 0.
- R10: After reset, all registers are zero, the block is disabled, and the three strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync, polarity per control bit 1 |
| vsync | output | 1 | Vertical sync, polarity per control bit 2 |
| de | output | 1 | Data enable, polarity per control bit 3 |
| pclk_falling | output | 1 | Pixel-clock edge select for the pad logic |
| px_x | output | 12 | Current column counter |
| px_y | output | 11 | Current line counter |

## Verification
The copy for a vertical-blanking reload and the wrap of both counters fall on the same edge, and the bench provokes this in two ways. First, it requests a vertical-blanking reload in the middle of a frame. It then checks that the last line of that frame still uses the old totals and that the first line of the next frame uses the new ones. Second, it places a request exactly on a frame-end edge and expects the copy to wait a whole frame. A cycle model built from the requirements predicts every output on every clock, so the line length and the strobe positions around each wrap are compared clock by clock.

// File: rtl/disp_timing_gen.sv
module disp_timing_gen #(
  parameter int HW = 12,
  parameter int VW = 11,
  parameter int HLSB = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [31:0]   wr_data,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          pclk_falling,
  output logic [HW-1:0] px_x,
  output logic [VW-1:0] px_y
);
  localparam int NB = 4;
  localparam logic [2:0] A_CTRL = 3'd4;
  localparam logic [2:0] A_RELOAD = 3'd5;

  logic [HW-1:0] sh_h [NB];
  logic [VW-1:0] sh_v [NB];
  logic [HW-1:0] cur_h [NB];
  logic [VW-1:0] cur_v [NB];
  logic [4:0] ctrl;
  logic imm_pend, vb_pend;
  logic en, h_wrap, frame_end, do_copy;
  logic hs_a, vs_a, de_a;
  logic unused_data;

  assign unused_data = ^wr_data;
  assign en = ctrl[0];
  assign h_wrap = px_x >= cur_h[3];
  assign frame_end = en && h_wrap && (px_y >= cur_v[3]);
  assign do_copy = imm_pend || (vb_pend && frame_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      imm_pend <= 1'b0;
      vb_pend <= 1'b0;
    end else begin
      if (imm_pend) imm_pend <= 1'b0;
      if (vb_pend && frame_end) vb_pend <= 1'b0;
      if (wr_en && wr_addr == A_CTRL) ctrl <= wr_data[4:0];
      if (wr_en && wr_addr == A_RELOAD) begin
        if (wr_data[0]) imm_pend <= 1'b1;
        if (wr_data[1]) vb_pend <= 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_h[i] <= '0;
        sh_v[i] <= '0;
        cur_h[i] <= '0;
        cur_v[i] <= '0;
      end else begin
        if (do_copy) begin
          cur_h[i] <= sh_h[i];
          cur_v[i] <= sh_v[i];
        end
        if (wr_en && wr_addr == 3'(i)) begin
          sh_h[i] <= wr_data[HLSB +: HW];
          sh_v[i] <= wr_data[0 +: VW];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px_x <= '0;
      px_y <= '0;
    end else if (!en) begin
      px_x <= '0;
      px_y <= '0;
    end else if (h_wrap) begin
      px_x <= '0;
      px_y <= (px_y >= cur_v[3]) ? '0 : px_y + 1'b1;
    end else begin
      px_x <= px_x + 1'b1;
    end
  end

  assign hs_a = en && (px_x <= cur_h[0]);
  assign vs_a = en && (px_y <= cur_v[0]);
  assign de_a = en && (px_x > cur_h[1]) && (px_x <= cur_h[2])
                   && (px_y > cur_v[1]) && (px_y <= cur_v[2]);

  assign hsync = hs_a ~^ ctrl[1];
  assign vsync = vs_a ~^ ctrl[2];
  assign de = de_a ~^ ctrl[3];
  assign pclk_falling = ctrl[4];
endmodule

// File: rtl/disp_timing_gen_chk.sv
module disp_timing_gen_chk #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic [31:0]   wr_data,
  input logic          imm_pend,
  input logic [HW-1:0] sh_tot_h,
  input logic [HW-1:0] cur_tot_h,
  input logic          de,
  input logic          de_high,
  input logic [HW-1:0] px_x,
  input logic [VW-1:0] px_y
);
  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (px_x == '0 && px_y == '0));

  assert_x_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    px_x != '0 |-> px_x == HW'($past(px_x) + 1));

  assert_y_moves_on_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    px_y != $past(px_y) |-> px_x == '0);

  assert_de_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (de == de_high) |-> en);

  assert_imm_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    imm_pend |=> cur_tot_h == $past(sh_tot_h));

  assert_imm_selfclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_pend && !(wr_en && wr_addr == 3'd5 && wr_data[0])) |=> !imm_pend);
endmodule

bind disp_timing_gen disp_timing_gen_chk #(.HW(HW), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .imm_pend(imm_pend), .sh_tot_h(sh_h[3]),
  .cur_tot_h(cur_h[3]), .de(de), .de_high(ctrl[3]), .px_x(px_x), .px_y(px_y)
);

// File: tb/sim_disp_timing_gen.sv
`timescale 1ns/1ps
module sim_disp_timing_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic hsync, vsync, de, pclk_falling;
  logic [11:0] px_x;
  logic [10:0] px_y;

  int total = 0, bad = 0;
  bit finished = 0;

  int mh = 0, mv = 0;
  int ch[4] = '{0, 0, 0, 0};
  int cv[4] = '{0, 0, 0, 0};
  int sh[4] = '{0, 0, 0, 0};
  int sv[4] = '{0, 0, 0, 0};
  bit m_en = 0, m_imm = 0, m_vb = 0;
  bit [4:0] m_ctrl = '0;

  disp_timing_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync(hsync), .vsync(vsync), .de(de), .pclk_falling(pclk_falling),
    .px_x(px_x), .px_y(px_y)
  );

  always #2.5 clk = ~clk;

  function automatic int pack(int h, int v);
    return (h << 16) | v;
  endfunction

  task automatic chk(string tag, string sig, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (x=%0d y=%0d)", tag, sig, act, exp, mh, mv);
    end
  endtask

  function automatic bit at_frame_end();
    return m_en && mh >= ch[3] && mv >= cv[3];
  endfunction

  task automatic cyc(bit we, int addr, int data, string tag);
    bit hs_a, vs_a, de_a, fe;
    @(negedge clk);
    hs_a = m_en && mh <= ch[0];
    vs_a = m_en && mv <= cv[0];
    de_a = m_en && mh > ch[1] && mh <= ch[2] && mv > cv[1] && mv <= cv[2];
    chk({tag, "/R3"}, "px_x", int'(px_x), mh);
    chk({tag, "/R3"}, "px_y", int'(px_y), mv);
    chk({tag, "/R4"}, "hsync", int'(hsync), int'(m_ctrl[1] ? hs_a : !hs_a));
    chk({tag, "/R4"}, "vsync", int'(vsync), int'(m_ctrl[2] ? vs_a : !vs_a));
    chk({tag, "/R5"}, "de", int'(de), int'(m_ctrl[3] ? de_a : !de_a));
    chk({tag, "/R6"}, "pclk_falling", int'(pclk_falling), int'(m_ctrl[4]));
    wr_en = we;
    wr_addr = 3'(addr);
    wr_data = data;
    fe = at_frame_end();
    if (!m_en) begin mh = 0; mv = 0; end
    else if (mh >= ch[3]) begin mh = 0; mv = (mv >= cv[3]) ? 0 : mv + 1; end
    else mh++;
    if (m_imm || (m_vb && fe)) begin ch = sh; cv = sv; end
    m_imm = 0;
    if (fe) m_vb = 0;
    if (we) begin
      if (addr < 4) begin sh[addr] = (data >> 16) & 32'hFFF; sv[addr] = data & 32'h7FF; end
      else if (addr == 4) begin m_ctrl = data[4:0]; m_en = data[0]; end
      else if (addr == 5) begin
        if (data[0]) m_imm = 1;
        if (data[1]) m_vb = 1;
      end
    end
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, tag);
  endtask

  task automatic t_reset();
    idle(4, "R10");
  endtask

  // R2: word addresses and field positions
  task automatic t_program();
    cyc(1, 0, pack(1, 0), "R2");
    cyc(1, 1, pack(3, 1), "R2");
    cyc(1, 2, pack(7, 4), "R2");
    cyc(1, 3, pack(8, 5), "R2");
    cyc(1, 5, 1, "R7");
    idle(2, "R7");
    cyc(1, 4, 1, "R9");
    idle(120, "R7");
  endtask

  task automatic t_shadow_only();
    cyc(1, 0, pack(2, 1), "R1");
    cyc(1, 1, pack(4, 2), "R1");
    cyc(1, 2, pack(9, 5), "R1");
    cyc(1, 3, pack(10, 6), "R1");
    idle(70, "R1");
  endtask

  task automatic t_polarity();
    cyc(1, 4, 32'h1F, "R6");
    idle(60, "R6");
    cyc(1, 4, 32'h11, "R6");
    idle(20, "R6");
  endtask

  task automatic t_vblank();
    idle(7, "R8");
    cyc(1, 5, 2, "R8");
    idle(130, "R8");
    while (!at_frame_end()) cyc(0, 0, 0, "R8");
    cyc(1, 5, 2, "R8");
    idle(5, "R8");
    cyc(1, 3, pack(8, 5), "R8");
    idle(80, "R8");
    cyc(1, 3, pack(12, 3), "R8");
    idle(100, "R8");
  endtask

  task automatic t_disable();
    cyc(1, 4, 0, "R9");
    idle(20, "R9");
    cyc(1, 4, 1, "R9");
    idle(40, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_program();
    t_shadow_only();
    t_polarity();
    t_vblank();
    t_disable();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule